// File: doc/BRIEF.md
# Bidirectional Mailbox Doorbell Registers

This block carries 32-bit messages between a local processor bus and a host-side register port. It holds two banks of eight mailboxes. The outbound bank is written by the local side and read by the host. The inbound bank is written by the host and read by the local side. A write into a mailbox raises the doorbell bit for that mailbox in the status register of the receiving side. The receiver can then fetch the message and clear the doorbell.

Each side has its own status register, its own 8-bit enable register and its own level interrupt output. The interrupt is high while any enabled status bit is set. Both ports are plain single-cycle register interfaces: address, write strobe, 32-bit write data and registered read data. Both sides use the same offset map within their own windows:

| Offset | Register |
|---|---|
| 0x3A00 + 4n | outbound mailbox n |
| 0x3B00 + 4n | inbound mailbox n |
| 0x3C00 | the reading side's own doorbell status |
| 0x3C04 | the reading side's own interrupt enable |

Top module: `mbx_doorbell_regs`

## Requirements
- R1: After reset, every mailbox, status bit and enable bit reads as zero, and both interrupt outputs are low.
- R2: The local port reads and writes outbound mailbox n at offset 0x3A00 + 4n, for n from 0 to 7. Read data appears on the clock edge after the address is presented, so the read latency is one cycle.
- R3: A local write to outbound mailbox n sets bit n of the host status register at host offset 0x3C00. The host reads the outbound mailboxes at the same offsets.
- R4: A host write to inbound mailbox n at offset 0x3B00 + 4n stores the data. The local port can read that data back. The write also sets bit n of the local status register at local offset 0x3C00.
- R5: Some writes have no effect on any readable value: local writes to the inbound range 0x3B00–0x3B1C, and host writes to the outbound range 0x3A00–0x3A1C.
- R6: Writing 1 to a bit of the status register at 0x3C00 clears that bit. Only the side that owns the register can do this. Writing 0 leaves the bit unchanged. If a doorbell set and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: Each side has an enable register at 0x3C04. Its bits 7:0 are read/write and its upper bits read as zero. A side's interrupt output is the OR of its status bits ANDed bitwise with its enable bits.
- R8: Some offsets are unmapped: any offset with bits 1:0 not zero, and any offset outside the listed registers. Reads from them return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_addr | input | 14 | Local port byte offset |
| lcl_we | input | 1 | Local write strobe |
| lcl_wdata | input | 32 | Local write data |
| lcl_rdata | output | 32 | Local read data, one cycle after the address |
| lcl_irq | output | 1 | Local interrupt, driven by inbound doorbells |
| hst_addr | input | 14 | Host port byte offset |
| hst_we | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the address |
| hst_irq | output | 1 | Host interrupt, driven by outbound doorbells |

## Verification
The assertions assume that both ports share one clock domain and that each write strobe is valid for exactly one cycle with a settled address. The read-only checks assume that only the named writer touches a bank in a given cycle. To keep within this, the stimulus drives every input on the falling edge. It idles one port while the other writes, except in the one deliberate same-cycle test of doorbell set against clear. It writes only word-aligned offsets, except where it probes misaligned addresses that must read as zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_N  = 8;
    localparam int unsigned MBX_DW = 32;
    localparam int unsigned MBX_AW = 14;
    localparam logic [13:0] OFS_OUTB = 14'h3A00;
    localparam logic [13:0] OFS_INB  = 14'h3B00;
    localparam logic [13:0] OFS_STAT = 14'h3C00;
    localparam logic [13:0] OFS_EN   = 14'h3C04;
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank #(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 14,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [N*DW-1:0]      mbox_flat,
    output logic [N-1:0]         ring
);
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned LO = IW + 2;

    typedef struct packed {
        logic [N-1:0][DW-1:0] mbox;
    } bank_s;

    bank_s st_d, st_q;
    logic  hit;

    assign hit = wr_en && (wr_addr[AW-1:LO] == BASE[AW-1:LO]) && (wr_addr[1:0] == 2'b00);

    for (genvar i = 0; i < N; i++) begin : g_ring
        assign ring[i] = hit && (wr_addr[LO-1:2] == IW'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (ring[i]) st_d.mbox[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mbox_flat = st_q.mbox;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_MBOX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            ring[i] |=> (st_q.mbox[i] == $past(wr_data))); // R2
    end
    AST_MBOX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.mbox)); // R5
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 14,
    parameter logic [AW-1:0] STAT_OFS = '0,
    parameter logic [AW-1:0] EN_OFS   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ring,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  status,
    output logic [N-1:0]  enable,
    output logic          irq
);
    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] enable;
    } irq_s;

    irq_s         st_d, st_q;
    logic [N-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = (we && addr == STAT_OFS) ? wdata : '0;
        st_d.status = (st_q.status & ~clr) | ring;
        if (we && addr == EN_OFS) st_d.enable = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign enable = st_q.enable;
    assign irq    = |(st_q.status & st_q.enable);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ring) |=> ((st_q.status & $past(ring)) == $past(ring))); // R6
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == STAT_OFS && ring == '0) |=> ((st_q.status & $past(wdata)) == '0)); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.enable == '0) |-> !irq); // R7
endmodule

// File: rtl/mbx_doorbell_regs.sv
module mbx_doorbell_regs
    import mbx_pkg::*;
#(
    parameter int unsigned N  = MBX_N,
    parameter int unsigned DW = MBX_DW,
    parameter int unsigned AW = MBX_AW,
    parameter logic [AW-1:0] OUTB_BASE = OFS_OUTB,
    parameter logic [AW-1:0] INB_BASE  = OFS_INB,
    parameter logic [AW-1:0] STAT_ADR  = OFS_STAT,
    parameter logic [AW-1:0] EN_ADR    = OFS_EN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lcl_addr,
    input  logic          lcl_we,
    input  logic [DW-1:0] lcl_wdata,
    output logic [DW-1:0] lcl_rdata,
    output logic          lcl_irq,
    input  logic [AW-1:0] hst_addr,
    input  logic          hst_we,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    output logic          hst_irq
);
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned LO = IW + 2;

    typedef struct packed {
        logic [DW-1:0] lrd;
        logic [DW-1:0] hrd;
    } rd_s;

    rd_s                  rd_d, rd_q;
    logic [N-1:0][DW-1:0] outb_mb, inb_mb;
    logic [N-1:0]         outb_ring, inb_ring;
    logic [N-1:0]         lstat, len, hstat, hen;

    mbx_bank #(.N(N), .DW(DW), .AW(AW), .BASE(OUTB_BASE)) u_outb (
        .clk(clk), .rst_n(rst_n), .wr_en(lcl_we), .wr_addr(lcl_addr),
        .wr_data(lcl_wdata), .mbox_flat(outb_mb), .ring(outb_ring));

    mbx_bank #(.N(N), .DW(DW), .AW(AW), .BASE(INB_BASE)) u_inb (
        .clk(clk), .rst_n(rst_n), .wr_en(hst_we), .wr_addr(hst_addr),
        .wr_data(hst_wdata), .mbox_flat(inb_mb), .ring(inb_ring));

    mbx_irq #(.N(N), .AW(AW), .STAT_OFS(STAT_ADR), .EN_OFS(EN_ADR)) u_lirq (
        .clk(clk), .rst_n(rst_n), .ring(inb_ring), .we(lcl_we), .addr(lcl_addr),
        .wdata(lcl_wdata[N-1:0]), .status(lstat), .enable(len), .irq(lcl_irq));

    mbx_irq #(.N(N), .AW(AW), .STAT_OFS(STAT_ADR), .EN_OFS(EN_ADR)) u_hirq (
        .clk(clk), .rst_n(rst_n), .ring(outb_ring), .we(hst_we), .addr(hst_addr),
        .wdata(hst_wdata[N-1:0]), .status(hstat), .enable(hen), .irq(hst_irq));

    function automatic logic [DW-1:0] rd_sel(
        input logic [AW-1:0]        a,
        input logic [N-1:0][DW-1:0] ob,
        input logic [N-1:0][DW-1:0] ib,
        input logic [N-1:0]         st,
        input logic [N-1:0]         en
    );
        logic [DW-1:0] r;
        r = '0;
        if (a[1:0] == 2'b00) begin
            if      (a[AW-1:LO] == OUTB_BASE[AW-1:LO]) r = ob[a[LO-1:2]];
            else if (a[AW-1:LO] == INB_BASE[AW-1:LO])  r = ib[a[LO-1:2]];
            else if (a == STAT_ADR)                    r = DW'(st);
            else if (a == EN_ADR)                      r = DW'(en);
        end
        return r;
    endfunction

    always_comb begin
        rd_d     = rd_q;
        rd_d.lrd = rd_sel(lcl_addr, outb_mb, inb_mb, lstat, len);
        rd_d.hrd = rd_sel(hst_addr, outb_mb, inb_mb, hstat, hen);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign lcl_rdata = rd_q.lrd;
    assign hst_rdata = rd_q.hrd;

    AST_INB_RO_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_we && !hst_we) |=> $stable(inb_mb)); // R5
    AST_OUTB_RO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_we && !lcl_we) |=> $stable(outb_mb)); // R5
    AST_NO_INB_RING: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_we |-> (inb_ring == '0)); // R4
endmodule

// File: tb/mbx_doorbell_regs_bench.sv
module mbx_doorbell_regs_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [13:0] lcl_addr = '0, hst_addr = '0;
    logic        lcl_we = 0, hst_we = 0;
    logic [31:0] lcl_wdata = '0, hst_wdata = '0;
    logic [31:0] lcl_rdata, hst_rdata;
    logic        lcl_irq, hst_irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    mbx_doorbell_regs u_mbx_doorbell_regs (
        .clk(clk), .rst_n(rst_n),
        .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata),
        .lcl_rdata(lcl_rdata), .lcl_irq(lcl_irq),
        .hst_addr(hst_addr), .hst_we(hst_we), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_irq(hst_irq));

    typedef struct packed {
        logic        host;
        logic        we;
        logic [13:0] addr;
        logic [31:0] wd;
        logic        chk;
        logic [3:0]  req;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 14'h3A00, 32'h11111111, 1'b0, 4'd2, 32'h0},        // R2 write mbox0
        '{1'b0, 1'b0, 14'h3A00, 32'h0,        1'b1, 4'd2, 32'h11111111}, // R2 readback
        '{1'b0, 1'b1, 14'h3A1C, 32'hCAFEF00D, 1'b0, 4'd2, 32'h0},        // R2 write mbox7
        '{1'b0, 1'b0, 14'h3A1C, 32'h0,        1'b1, 4'd2, 32'hCAFEF00D}, // R2
        '{1'b1, 1'b0, 14'h3C00, 32'h0,        1'b1, 4'd3, 32'h00000081}, // R3 host doorbells 0,7
        '{1'b1, 1'b0, 14'h3A1C, 32'h0,        1'b1, 4'd3, 32'hCAFEF00D}, // R3 host view
        '{1'b1, 1'b1, 14'h3A04, 32'hDEADBEEF, 1'b0, 4'd5, 32'h0},        // R5 host write to outbound
        '{1'b1, 1'b0, 14'h3A04, 32'h0,        1'b1, 4'd5, 32'h0},        // R5
        '{1'b1, 1'b1, 14'h3B0C, 32'h12345678, 1'b0, 4'd4, 32'h0},        // R4 host write inbound 3
        '{1'b0, 1'b0, 14'h3B0C, 32'h0,        1'b1, 4'd4, 32'h12345678}, // R4
        '{1'b0, 1'b0, 14'h3C00, 32'h0,        1'b1, 4'd4, 32'h00000008}, // R4 local doorbell 3
        '{1'b0, 1'b1, 14'h3B0C, 32'hFFFFFFFF, 1'b0, 4'd5, 32'h0},        // R5 local write inbound
        '{1'b0, 1'b0, 14'h3B0C, 32'h0,        1'b1, 4'd5, 32'h12345678}, // R5
        '{1'b1, 1'b1, 14'h3C00, 32'h00000001, 1'b0, 4'd6, 32'h0},        // R6 clear bit0
        '{1'b1, 1'b0, 14'h3C00, 32'h0,        1'b1, 4'd6, 32'h00000080}, // R6
        '{1'b0, 1'b1, 14'h3E00, 32'h55555555, 1'b0, 4'd8, 32'h0},        // R8 unmapped write
        '{1'b0, 1'b0, 14'h3E00, 32'h0,        1'b1, 4'd8, 32'h0},        // R8
        '{1'b0, 1'b0, 14'h3A02, 32'h0,        1'b1, 4'd8, 32'h0},        // R8 misaligned
        '{1'b0, 1'b1, 14'h3C04, 32'hFFFFFFFF, 1'b0, 4'd7, 32'h0},        // R7 enable all
        '{1'b0, 1'b0, 14'h3C04, 32'h0,        1'b1, 4'd7, 32'h000000FF}  // R7 upper bits zero
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic lw, input logic [13:0] la, input logic [31:0] ld,
                       input logic hw, input logic [13:0] ha, input logic [31:0] hd);
        lcl_we = lw; lcl_addr = la; lcl_wdata = ld;
        hst_we = hw; hst_addr = ha; hst_wdata = hd;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(1, {31'b0, lcl_irq}, 32'h0);
        check(1, {31'b0, hst_irq}, 32'h0);
        cyc(0, 14'h3A00, 0, 0, 14'h3B1C, 0);
        check(1, lcl_rdata, 32'h0);
        check(1, hst_rdata, 32'h0);
        cyc(0, 14'h3C00, 0, 0, 14'h3C04, 0);
        check(1, lcl_rdata, 32'h0);
        check(1, hst_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].host) cyc(0, 14'h0, 0, VEC[i].we, VEC[i].addr, VEC[i].wd);
            else             cyc(VEC[i].we, VEC[i].addr, VEC[i].wd, 0, 14'h0, 0);
            if (VEC[i].chk)
                check(int'(VEC[i].req), VEC[i].host ? hst_rdata : lcl_rdata, VEC[i].exp);
        end

        // R7 local irq: status 0x08, enable 0xFF; host enable still zero
        check(7, {31'b0, lcl_irq}, 32'h1);
        check(7, {31'b0, hst_irq}, 32'h0);
        // R6 local clear of bit3 drops the local irq
        cyc(1, 14'h3C00, 32'h08, 0, 14'h0, 0);
        check(6, {31'b0, lcl_irq}, 32'h0);
        // R6 set wins: local rings mbox2 while host clears all its bits
        cyc(1, 14'h3A08, 32'hA5A5A5A5, 1, 14'h3C00, 32'hFF);
        cyc(0, 14'h0, 0, 0, 14'h3C00, 0);
        check(6, hst_rdata, 32'h00000004);
        // R7 host enable matches bit2, then a non-matching mask
        cyc(0, 14'h0, 0, 1, 14'h3C04, 32'h04);
        check(7, {31'b0, hst_irq}, 32'h1);
        cyc(0, 14'h0, 0, 1, 14'h3C04, 32'h02);
        check(7, {31'b0, hst_irq}, 32'h0);

        // R1 second reset wipes the mailboxes
        rst_n = 0;
        cyc(0, 14'h0, 0, 0, 14'h0, 0);
        rst_n = 1;
        cyc(0, 14'h3A1C, 0, 0, 14'h3C00, 0);
        check(1, lcl_rdata, 32'h0);
        check(1, hst_rdata, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule